// File: doc/BRIEF.md
# Descriptor-Driven Bus-Master Copy Engine

This block moves a run of 32-bit words across a shared memory bus without the processor touching each word. Software prepares a four-word command block in memory and then makes a single register write that carries the block's address. The engine requests the bus and waits for a grant. It reads the command block, then alternates a read beat and a write beat for every word of the job. When the job ends it releases the bus and raises a level interrupt that software clears through a control register.

The command block holds four words at consecutive word addresses, in this order: the source address, the destination address, a mode word and a byte count. Mode bit 0 gives the direction. When the bit is 1 the copy runs from memory to a device: the source address advances and the destination stays on a fixed device register. When the bit is 0 the copy runs from a device to memory: the source stays fixed and the destination advances. Both sides move in word steps.

The memory port is a valid/ready handshake. A beat completes in the cycle where `mem_valid` and `mem_ready` are both high, and read data is taken from `mem_rdata` in that same cycle. The memory side applies back-pressure by holding `mem_ready` low. Until the beat completes, the engine keeps `mem_valid`, the address, the direction and the write data steady. The engine raises `mem_valid` only while it holds `bus_req` and sees `bus_grant`. The arbiter must not take the grant back while `bus_req` is high.

Top module: `desc_dma`

## Requirements
- R1: After reset, `irq`, `bus_req` and `mem_valid` are 0, the status code is idle and the pointer register reads 0.
- R2: A write to register offset 0 while the engine is idle or done stores the pointer and starts a job. `bus_req` is high from the next cycle, and no memory beat is issued until `bus_grant` is high.
- R3: The first four beats of a job are reads at pointer, pointer+4, pointer+8 and pointer+12, taken as source, destination, mode and byte count.
- R4: Each word is copied as a read at the current source followed by a write of that read data at the current destination. The word count is the byte count shifted right by two, so the two low bits of the count are ignored.
- R5: With mode bit 0 = 1, the source advances by 4 after each word and the destination stays fixed. With mode bit 0 = 0, the source stays fixed and the destination advances by 4. The other mode bits have no effect.
- R6: A byte count below 4 ends the job right after the fourth descriptor read, with no data beats, and raises the interrupt.
- R7: `irq` rises in the cycle the status code becomes done. It stays high until software writes register offset 1 with bit 0 = 1, and that write returns the status code to idle. A write with bit 0 = 0 has no effect.
- R8: A pointer write while the engine is fetching or transferring is ignored. The pointer readback keeps its value and the running job proceeds unchanged.
- R9: The status register (offset 2) shows the state in bits [1:0]: 0 idle, 1 fetching the command block, 2 transferring, 3 done. Bit 8 mirrors `irq`.
- R10: `mem_valid` is high only while both `bus_req` and `bus_grant` are high. `bus_req` falls in the cycle after the final beat of the job completes.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset: 0 pointer, 1 control, 2 status |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| bus_req | output | 1 | Request to own the memory bus |
| bus_grant | input | 1 | Bus ownership granted by the arbiter |
| mem_valid | output | 1 | Memory beat offered |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_write | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| irq | output | 1 | Job-complete interrupt, level |

## Verification
The copy is driven in both directions. A memory-to-device job with no wait states shows whether the source walks while the device address stays put. A device-to-memory job with two wait states and an odd byte count shows the mirror case, checks that the low count bits are dropped, and shows that beats hold steady under back-pressure. Byte counts of 0 and 3 separate a job that only fetches the command block from one that moves data. A pointer write during a job with slow memory shows whether a running job can be disturbed. The interrupt is then left pending and hit with a clear write of 0 and a clear write of 1, to show that only the second one clears it.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_READ,
    SQ_WRITE,
    SQ_DONE
  } sq_state_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_MOVE  = 2'd2,
    ST_DONE  = 2'd3
  } stat_code_t;

  localparam logic [1:0] RA_POINTER = 2'd0;
  localparam logic [1:0] RA_CONTROL = 2'd1;
  localparam logic [1:0] RA_STATUS  = 2'd2;

  localparam int DESC_WORDS = 4;
  localparam int IRQ_BIT    = 8;

  function automatic stat_code_t code_of(sq_state_t s);
    case (s)
      SQ_FETCH:          return ST_FETCH;
      SQ_READ, SQ_WRITE: return ST_MOVE;
      SQ_DONE:           return ST_DONE;
      default:           return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          busy,
  input  logic          job_end,
  input  stat_code_t    stat_in,
  output logic          start,
  output logic          clr,
  output logic [AW-1:0] cmd_ptr,
  output logic          irq
);

  logic [AW-1:0] ptr_q;
  logic          irq_q;

  assign start   = cfg_we && (cfg_addr == RA_POINTER) && !busy;
  assign clr     = cfg_we && (cfg_addr == RA_CONTROL) && cfg_wdata[0];
  assign cmd_ptr = ptr_q;
  assign irq     = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (start) ptr_q <= cfg_wdata[AW-1:0];
      if (job_end)  irq_q <= 1'b1;
      else if (clr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RA_POINTER: cfg_rdata = DW'(ptr_q);
      RA_STATUS: begin
        cfg_rdata[1:0]     = stat_in;
        cfg_rdata[IRQ_BIT] = irq_q;
      end
      default: cfg_rdata = '0;
    endcase
  end

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !clr |=> irq_q);

  // R7
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> stat_in == ST_DONE);

  // R8
  ptr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == RA_POINTER && busy |=> $stable(ptr_q));

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clr,
  input  logic [AW-1:0] cmd_ptr,
  output logic          busy,
  output logic          job_end,
  output stat_code_t    stat,
  output logic          op_valid,
  output logic          op_write,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_wdata,
  input  logic          op_ack,
  input  logic [DW-1:0] op_rdata
);

  localparam int STEP  = DW / 8;
  localparam int SHIFT = $clog2(STEP);
  localparam int CW    = DW - SHIFT;

  sq_state_t     state_q;
  logic [AW-1:0] src_q, dst_q;
  logic          to_dev_q;
  logic [CW-1:0] wleft_q;
  logic [1:0]    idx_q;
  logic [DW-1:0] buf_q;

  logic [CW-1:0] fetched_words;
  logic          last_fetch;

  assign fetched_words = op_rdata[DW-1:SHIFT];
  assign last_fetch    = (state_q == SQ_FETCH) && (idx_q == 2'(DESC_WORDS - 1));

  assign busy     = (state_q == SQ_FETCH) || (state_q == SQ_READ) || (state_q == SQ_WRITE);
  assign op_valid = busy;
  assign op_write = (state_q == SQ_WRITE);
  assign op_wdata = buf_q;
  assign stat     = code_of(state_q);
  assign job_end  = op_ack && ((last_fetch && fetched_words == '0) ||
                               (state_q == SQ_WRITE && wleft_q == CW'(1)));

  always_comb begin
    case (state_q)
      SQ_FETCH: op_addr = cmd_ptr + (AW'(idx_q) << SHIFT);
      SQ_READ:  op_addr = src_q;
      SQ_WRITE: op_addr = dst_q;
      default:  op_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      to_dev_q <= 1'b0;
      wleft_q  <= '0;
      idx_q    <= '0;
      buf_q    <= '0;
    end else begin
      case (state_q)
        SQ_IDLE, SQ_DONE: begin
          if (start) begin
            state_q <= SQ_FETCH;
            idx_q   <= '0;
          end else if (state_q == SQ_DONE && clr) begin
            state_q <= SQ_IDLE;
          end
        end
        SQ_FETCH: begin
          if (op_ack) begin
            case (idx_q)
              2'd0:    src_q    <= op_rdata[AW-1:0];
              2'd1:    dst_q    <= op_rdata[AW-1:0];
              2'd2:    to_dev_q <= op_rdata[0];
              default: wleft_q  <= fetched_words;
            endcase
            idx_q <= idx_q + 2'd1;
            if (last_fetch)
              state_q <= (fetched_words == '0) ? SQ_DONE : SQ_READ;
          end
        end
        SQ_READ: begin
          if (op_ack) begin
            buf_q   <= op_rdata;
            state_q <= SQ_WRITE;
          end
        end
        SQ_WRITE: begin
          if (op_ack) begin
            if (to_dev_q) src_q <= src_q + AW'(STEP);
            else          dst_q <= dst_q + AW'(STEP);
            wleft_q <= wleft_q - CW'(1);
            state_q <= (wleft_q == CW'(1)) ? SQ_DONE : SQ_READ;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R4
  words_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_READ || state_q == SQ_WRITE) |-> wleft_q != '0);

  // R6
  short_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_end && state_q == SQ_FETCH |=> state_q == SQ_DONE);

endmodule

// File: rtl/dmac_busif.sv
module dmac_busif #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          op_valid,
  input  logic          op_write,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          op_ack,
  output logic [DW-1:0] op_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  assign bus_req   = hold;
  assign mem_valid = op_valid && hold && bus_grant;
  assign mem_write = op_write;
  assign mem_addr  = op_addr;
  assign mem_wdata = op_wdata;
  assign op_ack    = mem_valid && mem_ready;
  assign op_rdata  = mem_rdata;

  // R10
  grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> bus_req && bus_grant);

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
      $stable(mem_write) && $stable(mem_wdata));

endmodule

// File: rtl/desc_dma.sv
module desc_dma
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);

  logic          start, clr, busy, job_end;
  logic [AW-1:0] cmd_ptr;
  stat_code_t    stat;
  logic          op_valid, op_write, op_ack;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata, op_rdata;

  dmac_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .busy(busy), .job_end(job_end), .stat_in(stat),
    .start(start), .clr(clr), .cmd_ptr(cmd_ptr), .irq(irq)
  );

  dmac_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .clr(clr), .cmd_ptr(cmd_ptr),
    .busy(busy), .job_end(job_end), .stat(stat),
    .op_valid(op_valid), .op_write(op_write), .op_addr(op_addr), .op_wdata(op_wdata),
    .op_ack(op_ack), .op_rdata(op_rdata)
  );

  dmac_busif #(.AW(AW), .DW(DW)) u_busif (
    .clk(clk), .rst_n(rst_n), .hold(busy),
    .op_valid(op_valid), .op_write(op_write), .op_addr(op_addr), .op_wdata(op_wdata),
    .op_ack(op_ack), .op_rdata(op_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

endmodule

// File: tb/test_desc_dma.sv
module test_desc_dma;

  localparam logic [31:0] DEV_RD = 32'h304;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus_req, bus_grant = 1'b0;
  logic        mem_valid, mem_ready = 1'b0, mem_write;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [31:0] mem [0:255];
  bit   grant_en = 0;
  int   wait_n = 0, wcnt = 0, dev_rd_n = 0;
  logic [31:0] log_addr [0:255];
  logic [31:0] log_data [0:255];
  logic        log_we   [0:255];
  int   log_n = 0;
  int   hold_viol = 0;
  logic prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;

  always #5ns clk = ~clk;

  desc_dma i_desc_dma (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq(irq)
  );

  assign mem_rdata = (mem_addr == DEV_RD) ? 32'hD000_0000 + dev_rd_n : mem[mem_addr[9:2]];

  // bus arbiter and memory with wait states
  always @(posedge clk) begin
    bus_grant <= bus_req && grant_en;
    prev_pend <= mem_valid && !mem_ready;
    prev_addr <= mem_addr;
    if (prev_pend && (!mem_valid || mem_addr != prev_addr)) hold_viol <= hold_viol + 1;
    if (mem_valid && mem_ready) begin
      mem_ready <= 1'b0;
      wcnt      <= 0;
      log_addr[log_n[7:0]] <= mem_addr;
      log_we[log_n[7:0]]   <= mem_write;
      log_data[log_n[7:0]] <= mem_write ? mem_wdata : mem_rdata;
      log_n <= log_n + 1;
      if (mem_write) mem[mem_addr[9:2]] <= mem_wdata;
      else if (mem_addr == DEV_RD) dev_rd_n <= dev_rd_n + 1;
    end else if (mem_valid) begin
      if (wcnt >= wait_n) mem_ready <= 1'b1;
      else wcnt <= wcnt + 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1ns;
    d = cfg_rdata;
  endtask

  task automatic wait_irq(int max, string req);
    int n = 0;
    while (!irq && n < max) begin
      @(negedge clk);
      n++;
    end
    check(req, {31'd0, irq}, 32'd1, "irq after job");
  endtask

  task automatic put_desc(int at, logic [31:0] s, logic [31:0] d, logic [31:0] m, logic [31:0] c);
    mem[at >> 2]       = s;
    mem[(at >> 2) + 1] = d;
    mem[(at >> 2) + 2] = m;
    mem[(at >> 2) + 3] = c;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(2'd2, v);
    check("R1", v, 32'd0, "status after reset");
    check("R1", {31'd0, irq}, 32'd0, "irq after reset");
    check("R1", {30'd0, bus_req, mem_valid}, 32'd0, "bus_req/mem_valid after reset");
    reg_read(2'd0, v);
    check("R1", v, 32'd0, "pointer after reset");
  endtask

  task automatic t_mem2dev();
    int base;
    logic [31:0] v;
    for (int k = 0; k < 3; k++) mem[64 + k] = 32'hCAFE_0000 + k;
    put_desc(32'h40, 32'h100, 32'h300, 32'h1, 32'd12);
    wait_n = 0; grant_en = 0; base = log_n;
    reg_write(2'd0, 32'h40);
    repeat (3) @(negedge clk);
    check("R2", {31'd0, bus_req}, 32'd1, "bus_req while waiting for grant");
    check("R2", {31'd0, mem_valid}, 32'd0, "no beat before grant");
    reg_read(2'd2, v);
    check("R9", v, 32'd1, "status fetching");
    grant_en = 1;
    wait_irq(300, "R7");
    check("R4", log_n - base, 10, "beat count mem-to-device");
    for (int k = 0; k < 4; k++) begin
      check("R3", log_addr[base + k], 32'h40 + 4 * k, "descriptor read address");
      check("R3", {31'd0, log_we[base + k]}, 32'd0, "descriptor beat is a read");
    end
    for (int k = 0; k < 3; k++) begin
      check("R5", log_addr[base + 4 + 2 * k], 32'h100 + 4 * k, "source advances");
      check("R5", log_addr[base + 5 + 2 * k], 32'h300, "device address fixed");
      check("R4", {31'd0, log_we[base + 5 + 2 * k]}, 32'd1, "second beat writes");
      check("R4", log_data[base + 5 + 2 * k], 32'hCAFE_0000 + k, "copied data");
    end
    reg_read(2'd2, v);
    check("R9", v, 32'h103, "status done with irq bit");
    check("R10", {31'd0, bus_req}, 32'd0, "bus released after job");
    reg_write(2'd1, 32'h1);
    reg_read(2'd2, v);
    check("R7", v, 32'd0, "status idle after clear");
  endtask

  task automatic t_dev2mem();
    int base, d0;
    mem[128] = 32'h5555_5555; mem[129] = 32'h5555_5555; mem[130] = 32'h5555_5555;
    put_desc(32'h50, DEV_RD, 32'h200, 32'h2, 32'd11);
    wait_n = 2; grant_en = 1; base = log_n; d0 = dev_rd_n;
    reg_write(2'd0, 32'h50);
    wait_irq(400, "R7");
    check("R4", log_n - base, 8, "beat count with odd byte count");
    check("R5", log_addr[base + 4], DEV_RD, "device source fixed word 0");
    check("R5", log_addr[base + 6], DEV_RD, "device source fixed word 1");
    check("R5", log_addr[base + 5], 32'h200, "destination word 0");
    check("R5", log_addr[base + 7], 32'h204, "destination advances");
    check("R4", mem[128], 32'hD000_0000 + d0, "stored word 0");
    check("R4", mem[129], 32'hD000_0001 + d0, "stored word 1");
    check("R4", mem[130], 32'h5555_5555, "low count bits ignored");
    check("R11", hold_viol, 0, "beat held under back-pressure");
    reg_write(2'd1, 32'h1);
  endtask

  task automatic t_short(logic [31:0] cnt);
    int base;
    logic [31:0] v;
    put_desc(32'h70, 32'h100, 32'h300, 32'h1, cnt);
    wait_n = 0; base = log_n;
    reg_write(2'd0, 32'h70);
    wait_irq(100, "R6");
    check("R6", log_n - base, 4, "only descriptor beats");
    reg_read(2'd2, v);
    check("R6", v, 32'h103, "done after short job");
  endtask

  task automatic t_irq_hold();
    logic [31:0] v;
    repeat (10) @(negedge clk);
    check("R7", {31'd0, irq}, 32'd1, "irq held while pending");
    reg_write(2'd1, 32'h0);
    check("R7", {31'd0, irq}, 32'd1, "clear with bit0=0 ignored");
    reg_write(2'd1, 32'h1);
    check("R7", {31'd0, irq}, 32'd0, "clear with bit0=1");
    reg_read(2'd2, v);
    check("R7", v, 32'd0, "idle after clear");
  endtask

  task automatic t_busy();
    int base, n;
    logic [31:0] v;
    bit seen;
    mem[64] = 32'h1111_0000; mem[65] = 32'h1111_0001;
    put_desc(32'h60, 32'h100, 32'h300, 32'h1, 32'd8);
    put_desc(32'h80, 32'h100, 32'h300, 32'h1, 32'd40);
    wait_n = 3; base = log_n;
    reg_write(2'd0, 32'h60);
    reg_write(2'd0, 32'h80);
    reg_read(2'd0, v);
    check("R8", v, 32'h60, "pointer kept during job");
    seen = 0; n = 0;
    while (!seen && n < 200) begin
      reg_read(2'd2, v);
      if (v[1:0] == 2'd2) seen = 1;
      n++;
    end
    check("R9", {31'd0, seen}, 32'd1, "status transferring observed");
    wait_irq(400, "R8");
    check("R8", log_n - base, 8, "job length unchanged");
    check("R8", log_addr[base], 32'h60, "job uses first pointer");
    check("R8", log_data[base + 7], 32'h1111_0001, "last copied word");
    reg_write(2'd1, 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mem2dev();
    t_dev2mem();
    t_short(32'd0);
    t_irq_hold();
    t_short(32'd3);
    reg_write(2'd1, 32'h1);
    t_busy();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule